// File: doc/BRIEF.md
# Indirect Table Access Controller

This block lets a host processor reach several wide internal tables through a narrow window of byte-wide registers. The host sets up a control byte that holds the direction, the target table and the top two address bits. For a write it also loads the data bytes. It then writes the low address byte, and that write starts the operation. A single request pulse goes to the table back-ends, carrying a 10-bit address and, for writes, a 67-bit data word.

Reads of the static address table and the VLAN table finish at a fixed time, two clock edges after the launching write. Reads of the dynamic address table and the statistics counters can take any number of cycles. For those two tables a status bit in the top data register reads 1 until the back-end returns a valid strobe. The 67-bit result is then latched in one step, so the host never sees a half-updated word. Three scratch bytes give the host and the device a simple mailbox.

The register map is: offsets 0-2 scratch, 3 control, 4 address low (launch), 5 data top (status and bits [66:64]), and 6-13 data bits [63:56] down to [7:0].

Top module: `itac_top`

## Requirements
- R1: After reset, every register reads 0x00, the status bit reads 0 and `be_req` is low. An assertion of `arst_n` during an operation abandons it and returns the block to that state.
- R2: Offsets 0, 1 and 2 are independent 8-bit scratch registers. Each reads back the last value written to it.
- R3: The control register at offset 3 reads back as written. Its fields are: bit 4 is the direction (1 = read, 0 = write), bits 3-2 are the table (00 static address, 01 VLAN, 10 dynamic address, 11 statistics counters), and bits 1-0 are address bits [9:8]. Writing it launches nothing.
- R4: A host write to offset 4 while the block is idle stores the byte and raises `be_req` for exactly one cycle. The pulse starts in the cycle after the write edge. During the pulse, `be_addr` = {control[1:0], written byte}, `be_tbl` = control[3:2] and `be_we` = NOT control[4].
- R5: During a write request, `be_wdata` carries the data registers. Offset 5 bits 2-0 supply bits [66:64]. Offsets 6 through 13 supply bytes [63:56] down to [7:0], so the least significant byte sits at offset 13.
- R6: A read of table 00 or 01 latches `be_rdata` at the second clock edge after the launching write. The status bit stays 0 throughout.
- R7: A read of table 10 or 11 sets the status bit (offset 5 bit 7) to 1 from the launching edge onward. The bit clears at the edge where `be_rvalid` is sampled high, and `be_rdata` is latched at that same edge. This holds even when `be_rvalid` arrives in the first cycle it can be accepted.
- R8: While a read is pending, the data registers keep their previous contents until the result is latched.
- R9: A write to offset 4 while an operation is in progress is ignored. No request is issued and the stored address-low byte is unchanged.
- R10: `be_rvalid` is ignored when no slow read is pending. The data registers and the status bit are unchanged.
- R11: Offset 5 bits 6-3 always read 0. Host writes to offset 5 update only bits 2-0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte for `host_addr` (combinational) |
| be_req | output | 1 | One-cycle request to the table back-end |
| be_we | output | 1 | 1 = write request, 0 = read request |
| be_tbl | output | 2 | Target table |
| be_addr | output | 10 | Table address |
| be_wdata | output | 67 | Write data |
| be_rdata | input | 67 | Read data from the back-end |
| be_rvalid | input | 1 | Read-complete strobe for the slow tables |

## Verification
The hardest situations to reach from the ports are the overlap cases: a second launch that lands while a slow read is still pending, and a completion strobe that arrives when nothing is waiting for it. The bench holds its slow back-end model open for a chosen number of cycles. During that window it writes the launch register again and reads the data bytes to confirm they are stale. It then fires `be_rvalid` at the earliest accepting cycle, and separately while idle. A fixed-time read is also overlapped with a launch in its second cycle, and reset is pulled in the middle of a pending read.

// File: rtl/itac_pkg.sv
package itac_pkg;

  typedef enum logic [1:0] {
    TBL_STATIC = 2'b00,
    TBL_VLAN   = 2'b01,
    TBL_DYN    = 2'b10,
    TBL_CNT    = 2'b11
  } tbl_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FIX   = 2'd2,
    ST_WAIT  = 2'd3
  } seq_e;

  // control byte layout, msb first
  typedef struct packed {
    logic [2:0] rsvd;
    logic       rd;
    tbl_e       tbl;
    logic [1:0] ahi;
  } ctrl_t;

  function automatic logic is_slow(input tbl_e t);
    return (t == TBL_DYN) || (t == TBL_CNT);
  endfunction

endpackage

// File: rtl/itac_rst_sync.sv
module itac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/itac_regs.sv
module itac_regs
  import itac_pkg::*;
#(
  parameter int DATA_W      = 67,
  parameter int NUM_SCRATCH = 3,
  parameter int REG_AW      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  input  logic              engaged,
  input  logic              status_busy,
  input  logic              res_vld,
  input  logic [DATA_W-1:0] res_data,
  output logic [7:0]        host_rdata,
  output ctrl_t             ctrl_q,
  output logic [7:0]        alo_q,
  output logic [DATA_W-1:0] data_q,
  output logic              launch
);

  localparam int NB       = (DATA_W + 7) / 8;
  localparam int LOW_W    = 8 * (NB - 1);
  localparam int TOP_BITS = DATA_W - LOW_W;
  localparam int CTRL_OFS = NUM_SCRATCH;
  localparam int ALO_OFS  = NUM_SCRATCH + 1;
  localparam int DATA_OFS = NUM_SCRATCH + 2;

  logic [7:0] scr_rd  [NUM_SCRATCH];
  logic [7:0] byte_rd [NB-1];

  // scratch bytes
  for (genvar s = 0; s < NUM_SCRATCH; s++) begin : g_scr
    logic       hit;
    logic [7:0] d, q;
    assign hit = host_we && (host_addr == REG_AW'(s));
    always_comb d = hit ? host_wdata : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign scr_rd[s] = q;
  end

  // control
  logic  ctrl_hit;
  ctrl_t ctrl_d;
  assign ctrl_hit = host_we && (host_addr == REG_AW'(CTRL_OFS));
  always_comb ctrl_d = ctrl_hit ? ctrl_t'(host_wdata) : ctrl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  // address low; a write here is the launch, refused while engaged
  logic [7:0] alo_d;
  assign launch = host_we && (host_addr == REG_AW'(ALO_OFS)) && !engaged;
  always_comb alo_d = launch ? host_wdata : alo_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alo_q <= '0;
    else        alo_q <= alo_d;
  end

  // low data bytes: byte i at offset DATA_OFS+NB-1-i
  for (genvar i = 0; i < NB - 1; i++) begin : g_byte
    logic       hit;
    logic [7:0] d, q;
    assign hit = host_we && (host_addr == REG_AW'(DATA_OFS + NB - 1 - i));
    always_comb begin
      if (res_vld)  d = res_data[8*i +: 8];
      else if (hit) d = host_wdata;
      else          d = q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign byte_rd[i]      = q;
    assign data_q[8*i +: 8] = q;
  end

  // top data bits
  logic                top_hit;
  logic [TOP_BITS-1:0] top_d, top_q;
  assign top_hit = host_we && (host_addr == REG_AW'(DATA_OFS));
  always_comb begin
    if (res_vld)      top_d = res_data[DATA_W-1:LOW_W];
    else if (top_hit) top_d = host_wdata[TOP_BITS-1:0];
    else              top_d = top_q;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) top_q <= '0;
    else        top_q <= top_d;
  end
  assign data_q[DATA_W-1:LOW_W] = top_q;

  // read mux
  always_comb begin
    host_rdata = '0;
    for (int s = 0; s < NUM_SCRATCH; s++) begin
      if (host_addr == REG_AW'(s)) host_rdata = scr_rd[s];
    end
    if (host_addr == REG_AW'(CTRL_OFS)) host_rdata = ctrl_q;
    if (host_addr == REG_AW'(ALO_OFS))  host_rdata = alo_q;
    if (host_addr == REG_AW'(DATA_OFS)) begin
      host_rdata[7]            = status_busy;
      host_rdata[TOP_BITS-1:0] = top_q;
    end
    for (int i = 0; i < NB - 1; i++) begin
      if (host_addr == REG_AW'(DATA_OFS + NB - 1 - i)) host_rdata = byte_rd[i];
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_vld && !host_we) |=> $stable(data_q)); // R8

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_hit |=> $stable(ctrl_q)); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == REG_AW'(DATA_OFS)) |-> (host_rdata[6:TOP_BITS] == '0)); // R11

endmodule

// File: rtl/itac_seq.sv
module itac_seq
  import itac_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  ctrl_t             ctrl_q,
  input  logic [7:0]        launch_lo,
  input  logic              be_rvalid,
  output logic              be_req,
  output logic              be_we,
  output tbl_e              be_tbl,
  output logic [ADDR_W-1:0] be_addr,
  output logic              engaged,
  output logic              status_busy,
  output logic              res_vld
);

  seq_e              state_q, state_d;
  logic              rd_q, rd_d;
  tbl_e              tbl_q, tbl_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              slow;

  assign slow = is_slow(tbl_q);

  // command capture, enabled by launch
  always_comb begin
    rd_d   = rd_q;
    tbl_d  = tbl_q;
    addr_d = addr_q;
    if (launch) begin
      rd_d   = ctrl_q.rd;
      tbl_d  = ctrl_q.tbl;
      addr_d = ADDR_W'({ctrl_q.ahi, launch_lo});
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (launch) state_d = ST_ISSUE;
      ST_ISSUE: begin
        if (!rd_q)     state_d = ST_IDLE;
        else if (slow) state_d = ST_WAIT;
        else           state_d = ST_FIX;
      end
      ST_FIX:   state_d = ST_IDLE;
      ST_WAIT:  if (be_rvalid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      tbl_q   <= TBL_STATIC;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      tbl_q   <= tbl_d;
      addr_q  <= addr_d;
    end
  end

  assign be_req      = (state_q == ST_ISSUE);
  assign be_we       = !rd_q;
  assign be_tbl      = tbl_q;
  assign be_addr     = addr_q;
  assign engaged     = (state_q != ST_IDLE);
  assign status_busy = (state_q == ST_WAIT) || ((state_q == ST_ISSUE) && rd_q && slow);
  assign res_vld     = (state_q == ST_FIX) || ((state_q == ST_WAIT) && be_rvalid);

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |=> !be_req); // R4

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_busy && !be_rvalid) |=> status_busy); // R7

  AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && be_rvalid) |=> !status_busy); // R7

  AST_FIXED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req && !be_we && !is_slow(be_tbl)) |=> (!status_busy && res_vld)); // R6

endmodule

// File: rtl/itac_top.sv
module itac_top
  import itac_pkg::*;
#(
  parameter int DATA_W      = 67,
  parameter int ADDR_W      = 10,
  parameter int NUM_SCRATCH = 3,
  parameter int REG_AW      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              host_we,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              be_req,
  output logic              be_we,
  output logic [1:0]        be_tbl,
  output logic [ADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata,
  input  logic [DATA_W-1:0] be_rdata,
  input  logic              be_rvalid
);

  localparam int ALO_OFS = NUM_SCRATCH + 1;

  logic  rst_n;
  logic  engaged, status_busy, res_vld, launch;
  ctrl_t ctrl_q;
  logic  [7:0] alo_q;
  tbl_e  tbl;

  itac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  itac_regs #(
    .DATA_W      (DATA_W),
    .NUM_SCRATCH (NUM_SCRATCH),
    .REG_AW      (REG_AW)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .engaged     (engaged),
    .status_busy (status_busy),
    .res_vld     (res_vld),
    .res_data    (be_rdata),
    .host_rdata  (host_rdata),
    .ctrl_q      (ctrl_q),
    .alo_q       (alo_q),
    .data_q      (be_wdata),
    .launch      (launch)
  );

  itac_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .ctrl_q      (ctrl_q),
    .launch_lo   (host_wdata),
    .be_rvalid   (be_rvalid),
    .be_req      (be_req),
    .be_we       (be_we),
    .be_tbl      (tbl),
    .be_addr     (be_addr),
    .engaged     (engaged),
    .status_busy (status_busy),
    .res_vld     (res_vld)
  );

  assign be_tbl = tbl;

  AST_LAUNCH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == REG_AW'(ALO_OFS) && !engaged) |=> be_req); // R4

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == REG_AW'(ALO_OFS) && engaged) |=> (!be_req && $stable(alo_q))); // R9

endmodule

// File: tb/itac_top_bench.sv
`timescale 1ns/1ps
module itac_top_bench;

  localparam int CTRL = 3, ALO = 4, DTOP = 5;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        be_req, be_we;
  logic [1:0]  be_tbl;
  logic [9:0]  be_addr;
  logic [66:0] be_wdata, be_rdata;
  logic [66:0] fix_rdata = '0;
  logic [66:0] slow_rdata = '0;
  logic        slow_sel = 1'b0;
  logic        be_rvalid = 1'b0;
  int          req_cnt = 0;
  int          checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  itac_top u_itac_top (
    .clk(clk), .arst_n(arst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .be_req(be_req),
    .be_we(be_we), .be_tbl(be_tbl), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_rdata(be_rdata), .be_rvalid(be_rvalid)
  );

  assign be_rdata = slow_sel ? slow_rdata : fix_rdata;

  function automatic logic [66:0] pat(input logic [1:0] t, input logic [9:0] a);
    return {a[2:0] ^ {1'b0, t}, 64'h0F1E_2D3C_4B5A_6978 ^ {t, 22'h0, a, 20'h0, a}};
  endfunction

  // behavioural fixed-time back-end and request counter
  always @(posedge clk) begin
    if (be_req) req_cnt <= req_cnt + 1;
    if (be_req && !be_we && !be_tbl[1]) fix_rdata <= pat(be_tbl, be_addr);
  end

  task automatic chk(input string tag, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 4'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    host_addr = 4'(a);
    #0.5;
    d = host_rdata;
  endtask

  task automatic rd_data(output logic [66:0] v);
    logic [7:0] b;
    rd(DTOP, b);
    v[66:64] = b[2:0];
    for (int k = 0; k < 8; k++) begin
      rd(6 + k, b);
      v[63-8*k -: 8] = b;
    end
  endtask

  task automatic status(output logic s);
    logic [7:0] b;
    rd(DTOP, b);
    s = b[7];
  endtask

  task automatic launch(input logic r, input logic [1:0] t, input logic [9:0] a);
    wr(CTRL, {3'b000, r, t, a[9:8]});
    wr(ALO, a[7:0]);
  endtask

  task automatic pulse_rvalid(input logic [66:0] v);
    @(negedge clk);
    slow_rdata = v; slow_sel = 1'b1; be_rvalid = 1'b1;
    @(negedge clk);
    be_rvalid = 1'b0; slow_sel = 1'b0;
  endtask

  // register write/readback vectors: {offset, write byte, expected readback}
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {4'd0, 8'hA5, 8'hA5},
    {4'd1, 8'h3C, 8'h3C},
    {4'd2, 8'hFF, 8'hFF},
    {4'd3, 8'hFB, 8'hFB},
    {4'd3, 8'h00, 8'h00},
    {4'd5, 8'hFF, 8'h07},
    {4'd6, 8'h12, 8'h12},
    {4'd13, 8'h34, 8'h34}
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [66:0] v, prev, w;
    logic        s;
    int          rc;

    // R1 reset state
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 14; a++) begin
      rd(a, b);
      chk("R1 reset register", 67'(b), 67'h0);
    end
    chk("R1 reset be_req", 67'(be_req), 67'h0);

    // R2 R3 R11 vector walk
    for (int n = 0; n < NV; n++) begin
      wr(int'(VEC[n][19:16]), VEC[n][15:8]);
      rd(int'(VEC[n][19:16]), b);
      chk("R2/R3/R11 readback", 67'(b), 67'(VEC[n][7:0]));
    end
    rd(0, b);
    chk("R2 scratch0 kept", 67'(b), 67'hA5);
    chk("R3 control write launches nothing", 67'(req_cnt), 67'h0);

    // R4 R5 write command
    w = 67'h5_DEAD_BEEF_CAFE_F00D;
    wr(DTOP, {5'b0, w[66:64]});
    for (int k = 0; k < 8; k++) wr(6 + k, w[63-8*k -: 8]);
    launch(1'b0, 2'b01, 10'h2C7);
    chk("R4 req high", 67'(be_req), 67'h1);
    chk("R4 be_we", 67'(be_we), 67'h1);
    chk("R4 be_tbl", 67'(be_tbl), 67'h1);
    chk("R4 be_addr", 67'(be_addr), 67'h2C7);
    chk("R5 be_wdata", be_wdata, w);
    @(negedge clk);
    chk("R4 req one cycle", 67'(be_req), 67'h0);
    chk("R4 request count", 67'(req_cnt), 67'h1);

    // R6 fixed reads
    launch(1'b1, 2'b00, 10'h155);
    status(s);
    chk("R6 status stays 0", 67'(s), 67'h0);
    chk("R4 read be_we", 67'(be_we), 67'h0);
    repeat (2) @(negedge clk);
    rd_data(v);
    chk("R6 static read data", v, pat(2'b00, 10'h155));
    launch(1'b1, 2'b01, 10'h3FF);
    repeat (2) @(negedge clk);
    rd_data(v);
    chk("R6 vlan read data", v, pat(2'b01, 10'h3FF));
    status(s);
    chk("R6 status after", 67'(s), 67'h0);

    // R7 R8 slow read of dynamic table
    prev = v;
    launch(1'b1, 2'b10, 10'h0AB);
    status(s);
    chk("R7 busy after launch", 67'(s), 67'h1);
    repeat (5) @(negedge clk);
    status(s);
    chk("R7 busy held", 67'(s), 67'h1);
    rd_data(v);
    chk("R8 data stale while pending", v, prev);
    pulse_rvalid(67'h6_1111_2222_3333_4444);
    status(s);
    chk("R7 busy cleared", 67'(s), 67'h0);
    rd_data(v);
    chk("R7 slow data latched", v, 67'h6_1111_2222_3333_4444);

    // R9 launch while slow read pending
    rc = req_cnt;
    launch(1'b1, 2'b11, 10'h010);
    repeat (2) @(negedge clk);
    wr(ALO, 8'h99);
    rd(ALO, b);
    chk("R9 address low unchanged", 67'(b), 67'h10);
    chk("R9 no second request", 67'(req_cnt), 67'(rc + 1));
    status(s);
    chk("R9 still busy", 67'(s), 67'h1);
    pulse_rvalid(67'h1_0000_0000_0000_00FF);
    rd_data(v);
    chk("R7 counters data", v, 67'h1_0000_0000_0000_00FF);

    // R9 launch during second cycle of a fixed read
    rc = req_cnt;
    launch(1'b1, 2'b00, 10'h020);
    wr(ALO, 8'h77);
    repeat (2) @(negedge clk);
    rd(ALO, b);
    chk("R9 fixed overlap alo", 67'(b), 67'h20);
    chk("R9 fixed overlap count", 67'(req_cnt), 67'(rc + 1));
    rd_data(v);
    chk("R9 fixed overlap data", v, pat(2'b00, 10'h020));

    // R10 stray completion strobe
    prev = v;
    rc = req_cnt;
    pulse_rvalid(67'h7_FFFF_FFFF_FFFF_FFFF);
    rd_data(v);
    chk("R10 stray rvalid data", v, prev);
    status(s);
    chk("R10 stray rvalid status", 67'(s), 67'h0);

    // R7 earliest completion
    launch(1'b1, 2'b11, 10'h301);
    pulse_rvalid(67'h2_ABCD_0000_1234_5678);
    status(s);
    chk("R7 minimum latency busy", 67'(s), 67'h0);
    rd_data(v);
    chk("R7 minimum latency data", v, 67'h2_ABCD_0000_1234_5678);

    // R1 reset in the middle of a pending read
    launch(1'b1, 2'b10, 10'h111);
    @(negedge clk);
    arst_n = 1'b0;
    #1;
    status(s);
    chk("R1 reset clears busy", 67'(s), 67'h0);
    rd_data(v);
    chk("R1 reset clears data", v, 67'h0);
    rd(0, b);
    chk("R1 reset clears scratch", 67'(b), 67'h0);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 no request after reset", 67'(be_req), 67'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule